// File: doc/BRIEF.md
# Oversampled Bitstream Pixel Resampler

This block turns a 1-bit video bitstream into packed pixel words. The bitstream is sampled at 20 samples per microsecond and arrives as 32-bit words, earliest sample in the most significant bit. The pixel clock of the source is not known in advance, so the block estimates it from the line lengths that a separate sync detector measures. During each frame it sums up to twenty plausible line lengths. From that sum it forms a 16.16 fixed-point pixel pitch in samples per pixel. From the pitch and a phase trim in 1/64-pixel steps it forms a start offset. Both values take effect only at the next frame boundary.

At every line start the block first throws away a fixed lead-in of words, keeping only the last one. It then walks a signed 16.16 bit pointer across the incoming words. For each pixel it picks one sample, inverts it and shifts it into a 32-bit output word. Ten words are produced per line, each with a store address taken from the line number. Finding sync and storing the frame are done by neighbouring blocks.

Top module: `pixel_resampler`

## Requirements
- R1: After reset `px_valid` and `word_take` are 0, the applied pitch is 0x00031900 and the applied start offset is 87 times that pitch. A line started before any `frame_start` uses these values.
- R2: A measurement counts only if all three conditions hold: `meas_line` is 5 or more, `meas_len` is strictly greater than 1240, and `meas_len` is strictly less than 1320. Only the first 20 qualifying measurements after a `frame_start` are summed.
- R3: When the 20th qualifying measurement arrives, the pending pitch becomes (sum << 16) / 8280, truncated to 32 bits.
- R4: On `frame_start` the applied start offset becomes 87*P + floor(trim*P/64), where P is the pending pitch and trim is the value present in that cycle.
- R5: The applied pitch and start offset change only on `frame_start`. `frame_start` also clears the sum and the count. If fewer than 20 measurements arrive, the pending pitch keeps its previous value.
- R6: After `line_start`, the first 6 words taken are discarded and only the last of them is kept as the current word. The pointer starts at start - ((sync_bits + 192) << 16).
- R7: While the signed pointer is greater than 0x200000, one word is taken per cycle in which `word_valid` is 1, and 0x200000 is subtracted for each. While `word_valid` is 0 the pointer holds.
- R8: Each pixel samples the current word at signed index pointer>>>16, where index 0 is bit 31. An index outside 0..31 samples as 0. The pixel value is the inverse of the sample, and the pointer then advances by the pitch.
- R9: Pixels are shifted in MSB first. Every 32 pixels give one `px_data` word, shown with a one-cycle `px_valid` pulse.
- R10: A line produces exactly 10 words at addresses line_idx*10 + k, for k = 0 to 9 in ascending order. After that `word_take` stays 0 until the next `line_start`.
- R11: `line_start` restarts the line from any state. No word is taken in the cycle in which `line_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe, applies pending pitch and start offset |
| trim | input | 8 | Phase trim in 1/64-pixel steps |
| meas_valid | input | 1 | Line length measurement strobe |
| meas_line | input | 9 | Line number of the measured line within the frame |
| meas_len | input | 12 | Measured line length in samples |
| line_start | input | 1 | Line start strobe |
| line_idx | input | 8 | Output row of the line being started |
| sync_bits | input | 8 | Samples already consumed by sync detection at line start |
| word_valid | input | 1 | A sample word is offered |
| word_data | input | 32 | Sample word, earliest sample in bit 31 |
| word_take | output | 1 | The offered word is consumed on this edge |
| px_valid | output | 1 | Pixel word strobe |
| px_addr | output | 12 | Store address of the pixel word |
| px_data | output | 32 | Pixel word, leftmost pixel in bit 31 |

## Verification
Lines are fed with four kinds of sample stream, and each shows a different failure. All-zero words show inversion. All-one words with a large sync offset push the pointer negative, which exercises the out-of-range sample rule. A repeating byte pattern and hashed words reveal any slip in which bit or which word is picked. Streams with a gap every third cycle show that stalls keep the pointer. A measurement sequence mixes skipped lines, values on both exact limits, and surplus values past the twentieth. Only the correct filter yields the pitch the later lines are checked against, and lines run before and after `frame_start` tell whether the new pitch was applied at the right time.

// File: rtl/pix_rs_pkg.sv
package pix_rs_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_DROP = 2'd1,
        SM_RUN  = 2'd2
    } smp_state_e;

    // Sample one bit of a word at a signed index counted from the MSB.
    function automatic logic pick_bit(input logic [WORD_W-1:0] w, input logic [15:0] pos);
        if (!pos[15] && pos < 16'd32)
            pick_bit = w[5'd31 - pos[4:0]];
        else
            pick_bit = 1'b0;
    endfunction

endpackage

// File: rtl/pix_pitch_est.sv
module pix_pitch_est
    import pix_rs_pkg::*;
#(
    parameter int SAMP_PER_US  = 20,
    parameter int LEN_W        = 12,
    parameter int LINE_W       = 9,
    parameter int TRIM_W       = 8,
    parameter int AVG_LINES    = 20,
    parameter int SKIP_LINES   = 4,
    parameter int LEN_LO_US    = 62,
    parameter int LEN_HI_US    = 66,
    parameter int LINE_PIXELS  = 414,
    parameter int START_PIXELS = 87,
    parameter int TRIM_FRAC    = 6,
    parameter logic [31:0] DEFAULT_INC = 32'h0003_1900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [TRIM_W-1:0] trim,
    input  logic              meas_valid,
    input  logic [LINE_W-1:0] meas_line,
    input  logic [LEN_W-1:0]  meas_len,
    output logic [31:0]       act_inc,
    output logic [31:0]       act_start
);
    localparam int CNT_W = $clog2(AVG_LINES + 1);
    localparam int ACC_W = LEN_W + CNT_W;
    localparam int NUM_W = ACC_W + 16;
    localparam logic [LINE_W-1:0] SKIP_V   = LINE_W'(SKIP_LINES);
    localparam logic [LEN_W-1:0]  LEN_LO_V = LEN_W'(LEN_LO_US * SAMP_PER_US);
    localparam logic [LEN_W-1:0]  LEN_HI_V = LEN_W'(LEN_HI_US * SAMP_PER_US);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(AVG_LINES);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(AVG_LINES - 1);
    localparam logic [NUM_W-1:0]  DIV_V    = NUM_W'(AVG_LINES * LINE_PIXELS);
    localparam logic [63:0]       START_V  = 64'(START_PIXELS);
    localparam logic [31:0]       RST_START = 32'(64'(DEFAULT_INC) * START_V);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      pend_inc;
        logic [31:0]      act_inc;
        logic [31:0]      act_start;
    } pitch_st_t;

    pitch_st_t st_d, st_q;
    logic             accept;
    logic [ACC_W-1:0] acc_sum;
    logic [31:0]      inc_new;
    logic [31:0]      start_new;

    always_comb begin
        st_d    = st_q;
        accept  = meas_valid && (meas_line > SKIP_V) && (meas_len > LEN_LO_V)
                  && (meas_len < LEN_HI_V) && (st_q.cnt < CNT_MAX);
        acc_sum = st_q.acc + ACC_W'(meas_len);
        inc_new = 32'({acc_sum, 16'b0} / DIV_V);
        start_new = 32'(64'(st_q.pend_inc) * START_V
                        + ((64'(st_q.pend_inc) * 64'(trim)) >> TRIM_FRAC));
        if (frame_start) begin
            st_d.act_inc   = st_q.pend_inc;
            st_d.act_start = start_new;
            st_d.acc       = '0;
            st_d.cnt       = '0;
        end else if (accept) begin
            st_d.acc = acc_sum;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_LAST)
                st_d.pend_inc = inc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc       <= '0;
            st_q.cnt       <= '0;
            st_q.pend_inc  <= DEFAULT_INC;
            st_q.act_inc   <= DEFAULT_INC;
            st_q.act_start <= RST_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_inc   = st_q.act_inc;
    assign act_start = st_q.act_start;

    // R5: applied values move only at a frame boundary
    p_frame_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_inc) && $stable(act_start)));

    // R2: no more than the configured number of lines are summed
    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R5: a frame boundary restarts the count
    p_count_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.cnt == '0));

endmodule

// File: rtl/pix_line_sampler.sv
module pix_line_sampler
    import pix_rs_pkg::*;
#(
    parameter int ROW_W          = 8,
    parameter int SYNC_W         = 8,
    parameter int ADDR_W         = 12,
    parameter int WORDS_PER_LINE = 10,
    parameter int DROP_WORDS     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       inc_in,
    input  logic [31:0]       start_in,
    input  logic              line_start,
    input  logic [ROW_W-1:0]  line_idx,
    input  logic [SYNC_W-1:0] sync_bits,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_take,
    output logic              px_valid,
    output logic [ADDR_W-1:0] px_addr,
    output logic [WORD_W-1:0] px_data
);
    localparam int WC_W = $clog2(WORDS_PER_LINE);
    localparam int DC_W = (DROP_WORDS > 1) ? $clog2(DROP_WORDS) : 1;
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [31:0]       STEP_V    = 32'(WORD_W) << 16;
    localparam logic [31:0]       DROP_BITS = 32'(DROP_WORDS * WORD_W);
    localparam logic [DC_W-1:0]   DROP_LAST = DC_W'(DROP_WORDS - 1);
    localparam logic [WC_W-1:0]   WORD_LAST = WC_W'(WORDS_PER_LINE - 1);
    localparam logic [BC_W-1:0]   BIT_LAST  = BC_W'(WORD_W - 1);
    localparam logic [ADDR_W-1:0] WPL_V     = ADDR_W'(WORDS_PER_LINE);

    typedef struct packed {
        smp_state_e        state;
        logic [31:0]       ptr;
        logic [31:0]       inc;
        logic [WORD_W-1:0] raw;
        logic [WORD_W-1:0] shreg;
        logic [DC_W-1:0]   dcnt;
        logic [BC_W-1:0]   bcnt;
        logic [WC_W-1:0]   wcnt;
        logic [ADDR_W-1:0] base;
        logic              pv;
        logic [ADDR_W-1:0] paddr;
        logic [WORD_W-1:0] pdata;
    } smp_st_t;

    smp_st_t st_d, st_q;
    logic              take;
    logic              need_word;
    logic              sample;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        st_d      = st_q;
        st_d.pv   = 1'b0;
        take      = 1'b0;
        need_word = $signed(st_q.ptr) > $signed(STEP_V);
        sample    = pick_bit(st_q.raw, st_q.ptr[31:16]);
        sh_next   = {st_q.shreg[WORD_W-2:0], ~sample};
        if (line_start) begin
            st_d.state = SM_DROP;
            st_d.dcnt  = '0;
            st_d.bcnt  = '0;
            st_d.wcnt  = '0;
            st_d.inc   = inc_in;
            st_d.ptr   = start_in - ((32'(sync_bits) + DROP_BITS) << 16);
            st_d.base  = ADDR_W'(line_idx) * WPL_V;
        end else begin
            case (st_q.state)
                SM_DROP: begin
                    if (word_valid) begin
                        take     = 1'b1;
                        st_d.raw = word_data;
                        if (st_q.dcnt == DROP_LAST)
                            st_d.state = SM_RUN;
                        else
                            st_d.dcnt = st_q.dcnt + DC_W'(1);
                    end
                end
                SM_RUN: begin
                    if (need_word) begin
                        if (word_valid) begin
                            take     = 1'b1;
                            st_d.raw = word_data;
                            st_d.ptr = st_q.ptr - STEP_V;
                        end
                    end else begin
                        st_d.shreg = sh_next;
                        st_d.ptr   = st_q.ptr + st_q.inc;
                        st_d.bcnt  = st_q.bcnt + BC_W'(1);
                        if (st_q.bcnt == BIT_LAST) begin
                            st_d.pv    = 1'b1;
                            st_d.pdata = sh_next;
                            st_d.paddr = st_q.base + ADDR_W'(st_q.wcnt);
                            if (st_q.wcnt == WORD_LAST)
                                st_d.state = SM_IDLE;
                            else
                                st_d.wcnt = st_q.wcnt + WC_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SM_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_take = take;
    assign px_valid  = st_q.pv;
    assign px_addr   = st_q.paddr;
    assign px_data   = st_q.pdata;

    // R9: each pixel word is a single-cycle pulse
    p_word_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> !px_valid);

    // R7: a starved fetch leaves the pointer where it was
    p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SM_RUN && need_word && !word_valid && !line_start)
        |=> $stable(st_q.ptr));

    // R11: a line start always restarts in the lead-in phase
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (st_q.state == SM_DROP && !px_valid));

    // R10: nothing is consumed once a line is complete
    p_idle_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SM_IDLE) |-> !word_take);

    // R11: the restart cycle consumes no word
    p_start_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !word_take);

endmodule

// File: rtl/pixel_resampler.sv
module pixel_resampler
    import pix_rs_pkg::*;
#(
    parameter int SAMP_PER_US    = 20,
    parameter int LEN_W          = 12,
    parameter int MEAS_LINE_W    = 9,
    parameter int ROW_W          = 8,
    parameter int SYNC_W         = 8,
    parameter int TRIM_W         = 8,
    parameter int ADDR_W         = 12,
    parameter int AVG_LINES      = 20,
    parameter int SKIP_LINES     = 4,
    parameter int LEN_LO_US      = 62,
    parameter int LEN_HI_US      = 66,
    parameter int LINE_PIXELS    = 414,
    parameter int START_PIXELS   = 87,
    parameter int DROP_US        = 10,
    parameter int WORDS_PER_LINE = 10,
    parameter logic [31:0] DEFAULT_INC = 32'h0003_1900
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic [TRIM_W-1:0]      trim,
    input  logic                   meas_valid,
    input  logic [MEAS_LINE_W-1:0] meas_line,
    input  logic [LEN_W-1:0]       meas_len,
    input  logic                   line_start,
    input  logic [ROW_W-1:0]       line_idx,
    input  logic [SYNC_W-1:0]      sync_bits,
    input  logic                   word_valid,
    input  logic [31:0]            word_data,
    output logic                   word_take,
    output logic                   px_valid,
    output logic [ADDR_W-1:0]      px_addr,
    output logic [31:0]            px_data
);
    localparam int DROP_WORDS = (DROP_US * SAMP_PER_US) / WORD_W;

    logic [31:0] act_inc;
    logic [31:0] act_start;

    pix_pitch_est #(
        .SAMP_PER_US (SAMP_PER_US),
        .LEN_W       (LEN_W),
        .LINE_W      (MEAS_LINE_W),
        .TRIM_W      (TRIM_W),
        .AVG_LINES   (AVG_LINES),
        .SKIP_LINES  (SKIP_LINES),
        .LEN_LO_US   (LEN_LO_US),
        .LEN_HI_US   (LEN_HI_US),
        .LINE_PIXELS (LINE_PIXELS),
        .START_PIXELS(START_PIXELS),
        .TRIM_FRAC   (6),
        .DEFAULT_INC (DEFAULT_INC)
    ) u_pitch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .trim       (trim),
        .meas_valid (meas_valid),
        .meas_line  (meas_line),
        .meas_len   (meas_len),
        .act_inc    (act_inc),
        .act_start  (act_start)
    );

    pix_line_sampler #(
        .ROW_W         (ROW_W),
        .SYNC_W        (SYNC_W),
        .ADDR_W        (ADDR_W),
        .WORDS_PER_LINE(WORDS_PER_LINE),
        .DROP_WORDS    (DROP_WORDS)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_in    (act_inc),
        .start_in  (act_start),
        .line_start(line_start),
        .line_idx  (line_idx),
        .sync_bits (sync_bits),
        .word_valid(word_valid),
        .word_data (word_data),
        .word_take (word_take),
        .px_valid  (px_valid),
        .px_addr   (px_addr),
        .px_data   (px_data)
    );

endmodule

// File: tb/sim_pixel_resampler.sv
module sim_pixel_resampler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [7:0]  trim = 8'd0;
    logic        meas_valid = 1'b0;
    logic [8:0]  meas_line = '0;
    logic [11:0] meas_len = '0;
    logic        line_start = 1'b0;
    logic [7:0]  line_idx = '0;
    logic [7:0]  sync_bits = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_take;
    logic        px_valid;
    logic [11:0] px_addr;
    logic [31:0] px_data;

    pixel_resampler u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .trim(trim),
        .meas_valid(meas_valid), .meas_line(meas_line), .meas_len(meas_len),
        .line_start(line_start), .line_idx(line_idx), .sync_bits(sync_bits),
        .word_valid(word_valid), .word_data(word_data), .word_take(word_take),
        .px_valid(px_valid), .px_addr(px_addr), .px_data(px_data)
    );

    always #2.5ns clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // stream and capture state
    int          widx = 0;
    bit          pend = 0;
    int          gcnt = 0;
    bit          stream_on = 0;
    bit          gap_on = 0;
    int          cur_seed = 0;
    bit          req_line = 0;
    logic [7:0]  req_idx = '0;
    logic [7:0]  req_sb = '0;
    int          ncap = 0;
    logic [31:0] got_d [16];
    logic [11:0] got_a [16];
    logic [31:0] exp_w [10];
    bit          late_take = 0;

    // expected control values
    logic [31:0] e_pend = 32'h0003_1900;
    logic [31:0] e_inc  = 32'h0003_1900;
    logic [31:0] e_start;

    // seed, sync_bits, line, trim, gap
    localparam logic [39:0] VECS [6] = '{
        {8'd3, 8'd0,   8'd0,   8'd162, 8'd0},
        {8'd2, 8'd17,  8'd239, 8'd0,   8'd1},
        {8'd1, 8'd40,  8'd5,   8'd255, 8'd0},
        {8'd0, 8'd200, 8'd100, 8'd64,  8'd1},
        {8'd4, 8'd3,   8'd57,  8'd125, 8'd0},
        {8'd5, 8'd99,  8'd12,  8'd31,  8'd1}
    };

    function automatic logic [31:0] word_at(input int seed, input int n);
        case (seed)
            0: word_at = 32'hFFFF_FFFF;
            1: word_at = 32'h0000_0000;
            2: word_at = 32'hA5A5_0F0F ^ (32'(n) * 32'h0101_0101);
            default: word_at = (32'(n) * 32'h9E37_79B1) ^ (32'(seed) * 32'h85EB_CA77)
                               ^ (32'(n) << 13);
        endcase
    endfunction

    function automatic logic [31:0] calc_start(input logic [31:0] inc, input logic [7:0] t);
        longint s;
        s = 87 * longint'(inc) + (longint'(t) * longint'(inc)) / 64;
        calc_start = s[31:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_all();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // reference walk of the bit pointer, from the requirements
    task automatic build_exp(input int seed, input logic [31:0] inc,
                             input logic [31:0] st, input int sb);
        int ptr;
        int n;
        int ix;
        logic [31:0] raw;
        logic [31:0] acc;
        logic bv;
        ptr = $signed(st) - ((sb + 192) * 65536);
        raw = word_at(seed, 5);
        n = 6;
        for (int w = 0; w < 10; w++) begin
            acc = '0;
            for (int b = 0; b < 32; b++) begin
                while (ptr > 32'sh0020_0000) begin
                    ptr = ptr - 32'sh0020_0000;
                    raw = word_at(seed, n);
                    n++;
                end
                ix = ptr >>> 16;
                bv = (ix >= 0 && ix < 32) ? raw[31 - ix] : 1'b0;
                acc = {acc[30:0], ~bv};
                ptr = ptr + $signed(inc);
            end
            exp_w[w] = acc;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            finish_all();
        end
    end

    always @(negedge clk) begin
        if (pend) widx = widx + 1;
        if (req_line) begin
            widx = 0;
            line_start = 1'b1;
            line_idx = req_idx;
            sync_bits = req_sb;
            req_line = 0;
        end else begin
            line_start = 1'b0;
        end
        gcnt++;
        word_valid = stream_on && !(gap_on && (gcnt % 3 == 0));
        word_data = word_at(cur_seed, widx);
        if (px_valid && ncap < 16) begin
            got_d[ncap] = px_data;
            got_a[ncap] = px_addr;
            ncap++;
        end
        #1ns pend = word_take;
    end

    task automatic do_frame(input logic [7:0] t);
        @(negedge clk);
        trim = t;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        e_inc = e_pend;
        e_start = calc_start(e_pend, t);
    endtask

    task automatic do_meas(input int ln, input int len);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_line = 9'(ln);
        meas_len = 12'(len);
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic start_line(input int seed, input int idx, input int sb);
        @(posedge clk);
        cur_seed = seed;
        req_idx = 8'(idx);
        req_sb = 8'(sb);
        ncap = 0;
        req_line = 1;
    endtask

    task automatic finish_line(input string tag, input int seed, input int idx, input int sb);
        int waitc;
        waitc = 0;
        while (ncap < 10 && waitc < 4000) begin
            @(posedge clk);
            waitc++;
        end
        late_take = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            #1ns if (word_take) late_take = 1;
        end
        chk({tag, " R10 word count"}, 32'(ncap), 32'd10);
        chk({tag, " R10 idle after line"}, 32'(late_take), 32'd0);
        build_exp(seed, e_inc, e_start, sb);
        for (int w = 0; w < 10; w++) begin
            chk({tag, " R9 data"}, got_d[w], exp_w[w]);
            chk({tag, " R10 addr"}, 32'(got_a[w]), 32'(idx * 10 + w));
        end
    endtask

    task automatic run_line(input string tag, input int seed, input int idx, input int sb);
        start_line(seed, idx, sb);
        finish_line(tag, seed, idx, sb);
    endtask

    initial begin
        int sum;
        int cnt;
        int lens [30];
        int lines [30];
        e_start = calc_start(32'h0003_1900, 8'd0);
        stream_on = 1;

        // R1: reset state
        repeat (4) @(negedge clk);
        #1ns;
        chk("R1 px_valid in reset", 32'(px_valid), 32'd0);
        chk("R1 word_take in reset", 32'(word_take), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1ns;
        chk("R1 word_take idle", 32'(word_take), 32'd0);
        chk("R1 px_valid idle", 32'(px_valid), 32'd0);

        // R1: default pitch and start before any frame boundary
        run_line("R1 default pitch", 4, 20, 10);

        // table walk: R4 R6 R7 R8
        foreach (VECS[i]) begin
            gap_on = VECS[i][0];
            do_frame(VECS[i][15:8]);
            run_line($sformatf("R4 R6 R7 R8 vector %0d", i),
                     int'(VECS[i][39:32]), int'(VECS[i][23:16]), int'(VECS[i][31:24]));
        end
        gap_on = 0;

        // R2 R3: measurement filter and pitch
        do_frame(8'd10);
        for (int i = 0; i < 4; i++) begin lines[i] = i + 1; lens[i] = 1300; end
        lines[4] = 5; lens[4] = 1240;
        lines[5] = 6; lens[5] = 1320;
        lines[6] = 7; lens[6] = 900;
        for (int k = 0; k < 20; k++) begin lines[7 + k] = 8 + k; lens[7 + k] = 1260 + 2 * k; end
        lines[27] = 28; lens[27] = 1319;
        lines[28] = 29; lens[28] = 1281;
        lines[29] = 30; lens[29] = 1250;
        sum = 0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            do_meas(lines[i], lens[i]);
            if (lines[i] >= 5 && lens[i] > 1240 && lens[i] < 1320 && cnt < 20) begin
                sum += lens[i];
                cnt++;
            end
        end
        e_pend = 32'((longint'(sum) << 16) / 8280);

        // R5: not applied before the frame boundary
        run_line("R5 old pitch kept", 4, 1, 0);
        do_frame(8'd162);
        run_line("R2 R3 measured pitch", 3, 2, 5);

        // R5: no measurements keep pending pitch
        do_frame(8'd90);
        run_line("R5 pending kept", 5, 3, 8);

        // R5: count cleared, new sum of twenty
        for (int k = 0; k < 20; k++) do_meas(10 + k, 1280);
        e_pend = 32'((longint'(25600) << 16) / 8280);
        do_frame(8'd0);
        gap_on = 1;
        run_line("R5 second measurement", 2, 4, 60);
        gap_on = 0;

        // R11: restart during lead-in
        start_line(4, 30, 0);
        repeat (3) @(posedge clk);
        start_line(6, 31, 5);
        finish_line("R11 restart", 6, 31, 5);

        // R11: restart in the middle of pixel output
        start_line(3, 40, 0);
        while (ncap < 3) @(posedge clk);
        start_line(2, 41, 22);
        finish_line("R11 mid-line restart", 2, 41, 22);

        finish_all();
    end

endmodule